// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error-Tagged Receive Queue

This block recovers asynchronous serial characters from a single receive line. A free-running sample tick, pulsed at sixteen times the bit rate, drives all timing. The line is first synchronised to the core clock. A falling level starts a candidate frame, which becomes a real one only if the line is still low at the middle of the start bit. Data bits are then sampled at their midpoints, least significant bit first. The character length is set by a two-bit code. The stop bit is sampled at its midpoint as well.

Each finished character is written into a receive queue together with four status bits, and the start and stop bits are discarded. The queue holds sixteen entries when queueing is enabled and a single entry when it is not. A read strobe removes the oldest entry. The read word shows the oldest entry whenever the queue is not empty. Empty and full flags let the consumer pace its reads.

Top module: `uartRxFifo`

## Requirements
- R1: After reset the empty flag is 1, the full flag is 0 and the read word is all zeros.
- R2: A frame of one low start bit, eight data bits sent least significant bit first and a high stop bit stores the data value in read-word bits 7..0.
- R3: The length code selects the character size: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits above the selected length read as zero.
- R4: A low pulse shorter than half a bit period, which is high again at the eighth tick after detection, stores no character.
- R5: Read-word bit 8 is 1 when the stop-bit sample is low and 0 when it is high. Bits 9 and 10 always read as zero.
- R6: The empty flag stays high until the stop bit's mid-point sample and falls one clock after that sample.
- R7: With queueing enabled (enable input 1), sixteen characters are held and read back in arrival order, and the full flag is 1 exactly when all sixteen are held.
- R8: With queueing disabled (enable input 0), one character is held and the full flag rises as soon as it is stored.
- R9: A character that arrives while the queue is full is discarded. Read-word bit 11 is set on the next character that is stored, and only on that one.
- R10: While the receive enable is 0, frames on the line store nothing.
- R11: The read strobe removes the oldest entry. A read strobe while the queue is empty has no effect, and the read word is zero while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| sampleTick | input | 1 | One-clock pulse at 16x the bit rate |
| wordLenCode | input | 2 | Character length code: 0..3 selects 5..8 bits |
| fifoEn | input | 1 | 1: sixteen-entry queue, 0: single entry |
| rxEnable | input | 1 | Receiver enable |
| readStrobe | input | 1 | Pops the oldest entry |
| readWord | output | 12 | Bits 7..0 character, 8 framing, 9 parity (0), 10 break (0), 11 overrun |
| rxEmpty | output | 1 | Queue holds no entry |
| rxFull | output | 1 | Queue holds its full capacity |

## Verification
With one tick every four clocks, a bit lasts 64 clocks. A start is confirmed 8 ticks after detection, and the detection itself falls 2 to 6 clocks after the edge because of the two-stage synchroniser. The stop sample therefore lands 610 to 614 clocks after the start edge, and the stored entry shows on the flags one clock later. The bench checks that the empty flag is still high 600 clocks into a frame and low at its 640-clock end. Every other result is sampled only after a frame and a two-bit idle gap have passed. Pops are checked on the falling edge after the strobe's rising edge, when the registered count has already moved.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned CHAR_W   = 8;
  localparam int unsigned MIN_CHAR = 5;
  localparam int unsigned ERR_W    = 4;
  localparam int unsigned WORD_W   = CHAR_W + ERR_W;
  localparam int unsigned POS_W    = $clog2(CHAR_W);

  // Strobes from the frame controller to the datapath
  typedef struct packed {
    logic             clearChar;
    logic             loadBit;
    logic [POS_W-1:0] bitPos;
    logic             bitVal;
    logic             pushChar;
    logic             frameErr;
  } rxStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rxState_t;
endpackage

// File: rtl/uartRxCtrl.sv
module uartRxCtrl
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxd,
  input  logic       sampleTick,
  input  logic [1:0] wordLenCode,
  input  logic       rxEnable,
  output rxStrobe_t  strobes
);
  localparam int unsigned CNT_W = $clog2(OVERSAMPLE);
  localparam int unsigned HALF  = OVERSAMPLE / 2;

  logic             rxLine;
  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [POS_W-1:0] bitIdx;
  logic [POS_W-1:0] lastIdx;
  logic             fullPeriod;
  logic             halfPeriod;

  // Line synchroniser, depth chosen by parameter
  generate
    if (SYNC_STAGES > 1) begin : g_syncChain
      logic [SYNC_STAGES-1:0] syncReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '1;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], rxd};
      end
      assign rxLine = syncReg[SYNC_STAGES-1];
    end else begin : g_syncSingle
      logic syncReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= 1'b1;
        else       syncReg <= rxd;
      end
      assign rxLine = syncReg;
    end
  endgenerate

  assign fullPeriod = (tickCnt == CNT_W'(OVERSAMPLE - 1));
  assign halfPeriod = (tickCnt == CNT_W'(HALF - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      lastIdx <= '0;
    end else if (!rxEnable) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
    end else if (sampleTick) begin
      case (state)
        ST_IDLE: begin
          if (!rxLine) begin
            state   <= ST_START;
            tickCnt <= '0;
            lastIdx <= POS_W'(MIN_CHAR - 1) + POS_W'(wordLenCode);
          end
        end
        ST_START: begin
          if (halfPeriod) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= rxLine ? ST_IDLE : ST_DATA;
          end else begin
            tickCnt <= tickCnt + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (fullPeriod) begin
            tickCnt <= '0;
            if (bitIdx == lastIdx) state <= ST_STOP;
            else                   bitIdx <= bitIdx + POS_W'(1);
          end else begin
            tickCnt <= tickCnt + CNT_W'(1);
          end
        end
        default: begin
          if (fullPeriod) begin
            tickCnt <= '0;
            state   <= ST_IDLE;
          end else begin
            tickCnt <= tickCnt + CNT_W'(1);
          end
        end
      endcase
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.bitPos    = bitIdx;
    strobes.bitVal    = rxLine;
    strobes.frameErr  = !rxLine;
    strobes.clearChar = rxEnable && sampleTick && (state == ST_IDLE) && !rxLine;
    strobes.loadBit   = rxEnable && sampleTick && (state == ST_DATA) && fullPeriod;
    strobes.pushChar  = rxEnable && sampleTick && (state == ST_STOP) && fullPeriod;
  end

  // R10: disabling the receiver parks the controller
  a_r10_idle_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (state == ST_IDLE));

  // R4: data phase entered only from a start still low at mid-bit
  a_r4_start_confirmed: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && $past(state) == ST_START) |-> !$past(rxLine));

  // R3: bit index never exceeds the selected length
  a_r3_bit_in_range: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadBit |-> (bitIdx <= lastIdx));
endmodule

// File: rtl/uartRxDatapath.sv
module uartRxDatapath
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobes,
  input  logic              fifoEn,
  input  logic              readStrobe,
  output logic [WORD_W-1:0] readWord,
  output logic              rxEmpty,
  output logic              rxFull
);
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);

  logic [CHAR_W-1:0] charReg;
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  capLimit;
  logic              overrunPend;
  logic              popOk;
  logic              pushOk;
  logic              dropEvt;
  logic [WORD_W-1:0] pushWord;
  logic [WORD_W-1:0] entryArr [DEPTH];

  // Character assembly, LSB first by bit position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  charReg <= '0;
    else if (strobes.clearChar) charReg <= '0;
    else if (strobes.loadBit)   charReg[strobes.bitPos] <= strobes.bitVal;
  end

  // bit 11 overrun, 10 break, 9 parity, 8 framing
  assign pushWord = {overrunPend, 1'b0, 1'b0, strobes.frameErr, charReg};

  assign capLimit = fifoEn ? CNT_W'(DEPTH) : CNT_W'(1);
  assign rxEmpty  = (count == '0);
  assign rxFull   = (count >= capLimit);
  assign popOk    = readStrobe && !rxEmpty;
  assign pushOk   = strobes.pushChar && (!rxFull || popOk);
  assign dropEvt  = strobes.pushChar && !pushOk;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      logic [WORD_W-1:0] entryQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                   entryQ <= '0;
        else if (pushOk && wrPtr == ADDR_W'(i))      entryQ <= pushWord;
      end
      assign entryArr[i] = entryQ;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr       <= '0;
      rdPtr       <= '0;
      count       <= '0;
      overrunPend <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == ADDR_W'(DEPTH - 1)) ? '0 : wrPtr + ADDR_W'(1);
      if (popOk)  rdPtr <= (rdPtr == ADDR_W'(DEPTH - 1)) ? '0 : rdPtr + ADDR_W'(1);
      case ({pushOk, popOk})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      if (dropEvt)     overrunPend <= 1'b1;
      else if (pushOk) overrunPend <= 1'b0;
    end
  end

  assign readWord = rxEmpty ? '0 : entryArr[rdPtr];

  // R7: occupancy bounded by depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R8: single-entry mode never grows past one
  a_r8_single_entry: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && count == CNT_W'(1) && !readStrobe) |=> (count == CNT_W'(1)));

  // R9: a dropped character arms the overrun tag
  a_r9_overrun_armed: assert property (@(posedge clk) disable iff (!rstN)
    dropEvt |=> overrunPend);

  // R6: empty only falls after a completed stop sample
  a_r6_empty_after_push: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxEmpty) |-> $past(strobes.pushChar));

  // R11: a lone pop removes exactly one entry
  a_r11_pop_one: assert property (@(posedge clk) disable iff (!rstN)
    (popOk && !pushOk) |=> (count == $past(count) - CNT_W'(1)));
endmodule

// File: rtl/uartRxFifo.sv
module uartRxFifo
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEPTH       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxd,
  input  logic              sampleTick,
  input  logic [1:0]        wordLenCode,
  input  logic              fifoEn,
  input  logic              rxEnable,
  input  logic              readStrobe,
  output logic [WORD_W-1:0] readWord,
  output logic              rxEmpty,
  output logic              rxFull
);
  rxStrobe_t strobes;

  uartRxCtrl #(
    .OVERSAMPLE (OVERSAMPLE),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxd        (rxd),
    .sampleTick (sampleTick),
    .wordLenCode(wordLenCode),
    .rxEnable   (rxEnable),
    .strobes    (strobes)
  );

  uartRxDatapath #(
    .DEPTH(DEPTH)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .fifoEn    (fifoEn),
    .readStrobe(readStrobe),
    .readWord  (readWord),
    .rxEmpty   (rxEmpty),
    .rxFull    (rxFull)
  );
endmodule

// File: tb/uartRxFifo_tb.sv
module uartRxFifo_tb;
  localparam int BITCLK = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxd = 1'b1;
  logic        sampleTick = 1'b0;
  logic [1:0]  wordLenCode = 2'd3;
  logic        fifoEn = 1'b1;
  logic        rxEnable = 1'b1;
  logic        readStrobe = 1'b0;
  logic [11:0] readWord;
  logic        rxEmpty;
  logic        rxFull;

  int nTests = 0;
  int nFail  = 0;

  // {wordLenCode[1:0], stopHigh, data[7:0]}
  localparam logic [10:0] VECS [0:8] = '{
    {2'd3, 1'b1, 8'hA5}, {2'd3, 1'b1, 8'h3C}, {2'd3, 1'b0, 8'h81},
    {2'd0, 1'b1, 8'hFF}, {2'd1, 1'b1, 8'h2A}, {2'd2, 1'b1, 8'h55},
    {2'd0, 1'b0, 8'h0E}, {2'd3, 1'b1, 8'h00}, {2'd3, 1'b1, 8'hFF}
  };

  uartRxFifo u_dut (
    .clk(clk), .rstN(rstN), .rxd(rxd), .sampleTick(sampleTick),
    .wordLenCode(wordLenCode), .fifoEn(fifoEn), .rxEnable(rxEnable),
    .readStrobe(readStrobe), .readWord(readWord), .rxEmpty(rxEmpty), .rxFull(rxFull)
  );

  always #10 clk = ~clk;

  // one tick every fourth clock
  initial begin
    int phase = 0;
    forever begin
      @(negedge clk);
      sampleTick = (phase == 3);
      phase = (phase + 1) % 4;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] expWord(input logic [1:0] code, input logic stopHigh,
                                          input logic [7:0] data, input logic ovr);
    logic [7:0] mask = 8'hFF >> (3 - code);
    return {ovr, 2'b00, ~stopHigh, data & mask};
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // frame followed by two idle bit periods; optional R6 probe inside stop bit
  task automatic sendFrame(input logic [7:0] data, input int nBits, input logic stopBit,
                           input bit probe);
    rxd = 1'b0;
    waitClk(BITCLK);
    for (int b = 0; b < nBits; b++) begin
      rxd = data[b];
      waitClk(BITCLK);
    end
    rxd = stopBit;
    waitClk(24);
    if (probe) check("R6 empty before stop sample", rxEmpty, 1'b1);
    waitClk(BITCLK - 24);
    if (probe) check("R6 empty after stop sample", rxEmpty, 1'b0);
    rxd = 1'b1;
    waitClk(2 * BITCLK);
  endtask

  task automatic popOne();
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    waitClk(5);
    // R1 reset state
    check("R1 empty", rxEmpty, 1'b1);
    check("R1 full", rxFull, 1'b0);
    check("R1 word", readWord, 12'h000);
    rstN = 1'b1;
    waitClk(5);

    // R6 latency probe with an 8-bit frame
    wordLenCode = 2'd3;
    sendFrame(8'h5A, 8, 1'b1, 1'b1);
    check("R2 probe word", readWord, 12'h05A);
    popOne();
    check("R11 empty after pop", rxEmpty, 1'b1);

    // vector table: R2, R3, R5
    for (int v = 0; v < 9; v++) begin
      wordLenCode = VECS[v][10:9];
      sendFrame(VECS[v][7:0], 5 + int'(VECS[v][10:9]), VECS[v][8], 1'b0);
      check("R2/R3/R5 word", readWord,
            expWord(VECS[v][10:9], VECS[v][8], VECS[v][7:0], 1'b0));
      check("R5 not empty", rxEmpty, 1'b0);
      popOne();
      check("R11 drained", rxEmpty, 1'b1);
    end
    wordLenCode = 2'd3;

    // R4 glitch: low for 3 ticks only
    rxd = 1'b0;
    waitClk(12);
    rxd = 1'b1;
    waitClk(3 * BITCLK);
    check("R4 glitch stores nothing", rxEmpty, 1'b1);

    // R10 receiver disabled
    rxEnable = 1'b0;
    sendFrame(8'hC3, 8, 1'b1, 1'b0);
    check("R10 disabled stores nothing", rxEmpty, 1'b1);
    rxEnable = 1'b1;
    waitClk(8);
    sendFrame(8'hC3, 8, 1'b1, 1'b0);
    check("R10 re-enabled word", readWord, 12'h0C3);
    popOne();

    // R11 pop on empty is ignored
    check("R11 empty word zero", readWord, 12'h000);
    popOne();
    check("R11 still empty", rxEmpty, 1'b1);
    sendFrame(8'h77, 8, 1'b1, 1'b0);
    check("R11 word after empty pop", readWord, 12'h077);
    check("R11 full stays low", rxFull, 1'b0);
    popOne();

    // R7 / R9 sixteen-entry queue and overrun
    fifoEn = 1'b1;
    for (int i = 0; i < 16; i++) begin
      sendFrame(8'h10 + 8'(i), 8, 1'b1, 1'b0);
      if (i == 14) check("R7 not full at 15", rxFull, 1'b0);
    end
    check("R7 full at 16", rxFull, 1'b1);
    sendFrame(8'hEE, 8, 1'b1, 1'b0);
    check("R9 still full after drop", rxFull, 1'b1);
    check("R9 head unchanged", readWord, 12'h010);
    popOne();
    sendFrame(8'h99, 8, 1'b1, 1'b0);
    check("R7 full again", rxFull, 1'b1);
    for (int i = 1; i < 16; i++) begin
      check("R7 order", readWord, {4'h0, 8'h10 + 8'(i)});
      popOne();
    end
    check("R9 overrun tagged", readWord, 12'h899);
    popOne();
    check("R7 drained", rxEmpty, 1'b1);
    sendFrame(8'h42, 8, 1'b1, 1'b0);
    check("R9 tag only once", readWord, 12'h042);
    popOne();

    // R8 single-entry mode
    fifoEn = 1'b0;
    sendFrame(8'hA1, 8, 1'b1, 1'b0);
    check("R8 full after one", rxFull, 1'b1);
    sendFrame(8'hB2, 8, 1'b1, 1'b0);
    check("R8 holds first", readWord, 12'h0A1);
    popOne();
    check("R8 empty after pop", rxEmpty, 1'b1);
    sendFrame(8'hC4, 8, 1'b1, 1'b0);
    check("R9 single-entry overrun", readWord, 12'h8C4);
    popOne();

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule